// File: doc/BRIEF.md
# Synchronous DRAM Device Command Front End

This block is a synthesizable device-side model of a four-bank synchronous DRAM with a 16-bit data path. It is meant to sit under a memory controller in a chip-level environment. On every rising clock edge it samples the command pins, the address bus, the two bank-select pins, the byte mask and the clock enable. It decodes the command, keeps one open row per bank, runs fixed four-beat bursts and returns read data two cycles after the read command.

Storage is a reduced array. Only the low row and column address bits are kept, so rows and columns that share those low bits alias onto the same word. The full 13-bit row and 9-bit column address are still accepted. A read or write aimed at a bank with no open row is dropped, and the block reports it with a one-cycle error pulse. A low clock enable freezes the next edge entirely.

Top module: `sdram_cmd_model`

## Requirements
- R1: After synchronous reset (rst_n low at an edge) all banks are closed, `dq_oe` is 00 and `bad_access` is 0.
- R2: With `cs_n` low on a valid edge, `{ras_n,cas_n,we_n}` decodes as 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. Refresh, mode set and no-op leave open rows and stored data unchanged.
- R3: With `cs_n` high, the command pins, address and bank select are ignored. A burst already under way still completes.
- R4: Activate opens the row given on `addr[12:0]` in the selected bank. Each bank keeps its own open row independently. The bank index is 2*`bank_sel[0]` + `bank_sel[1]`.
- R5: Precharge with `addr[10]`=1 closes all four banks. With `addr[10]`=0 it closes only the selected bank.
- R6: A read on edge R to an open bank with start column C = `addr[8:0]` drives four beats. Beat i is driven after edge R+2+i from column {C[8:2], (C[1:0]+i) mod 4}. After edge R+6, `dq_oe` returns to 00 if no new read follows.
- R7: A write takes beat 0 from `dq_in` on the command edge and beats 1 to 3 on the next three valid edges, in the same wrapping column order as reads.
- R8: During a write beat, `dqm[1]`=1 keeps the upper byte (bits 15:8) and `dqm[0]`=1 keeps the lower byte (bits 7:0) of the stored word unchanged. The mask applies on the same edge as the data.
- R9: During reads, `dqm[k]` sampled on edge E forces `dq_oe[k]` to 0 for the output driven after edge E+2.
- R10: A read or write to a closed bank changes no storage and drives no data. `bad_access` is 1 for exactly the one valid cycle after that command.
- R11: `cke` sampled low on edge E makes edge E+1 invalid. On an invalid edge no state changes, outputs hold and any command is ignored.
- R12: Storage keeps the low ROW_KEEP row bits and the low COL_KEEP column bits. With defaults 2 and 3, row 7 column 9 is the same word as row 3 column 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low makes the following edge invalid |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Command bit 2, active low |
| cas_n | input | 1 | Command bit 1, active low |
| we_n | input | 1 | Command bit 0, active low |
| bank_sel | input | 2 | Bank select; bit 0 has weight 2, bit 1 has weight 1 |
| addr | input | 13 | Row address on activate, column on read/write, bit 10 = precharge-all |
| dqm | input | 2 | Byte mask; bit 1 upper byte, bit 0 lower byte |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte output enable (0 = high impedance) |
| bad_access | output | 1 | One-cycle pulse on read/write to a closed bank |

## Verification
The bench sweeps every bank and all four start offsets within a column block. A design that wrapped into the next block, or counted from the wrong column, would return data from the wrong words. It places byte masks on single beats of reads and writes. A design with a read-mask delay one cycle off, or with the byte lanes swapped, blanks the wrong beat or byte. It drops the clock enable in the middle of the read-data window and puts a precharge-all on the frozen edge. A design that let the frozen edge advance the pipeline would skip a beat, and one that acted on the command would close the bank. It also issues commands with chip select high during a burst, writes to precharged banks, and reads through aliased row and column addresses. A design that honoured those commands, wrote the closed bank, or kept too many address bits would show changed or missing data.

// File: rtl/sdram_pkg.sv
`timescale 1ns/1ps
// Shared protocol constants and the decoded command type.
// Assumes a fixed burst of four beats and a read latency of two cycles.
package sdram_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int BURST_LEN = 4;
    localparam int BIDX_W    = 2;
    localparam int AP_BIT    = 10;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
// Turns the sampled command pins into one command per valid edge.
// Assumes: cs_n high or an invalid edge yields a no-op; bank_sel[0] is the high bank bit.
module sdram_cmd_decode
    import sdram_pkg::*;
(
    input  logic              edge_ok,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        bank_sel,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank
);
    // Decode the active-low command triple when selected on a valid edge.
    always_comb begin
        cmd = CMD_NOP;
        if (edge_ok && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // Bank index: first select pin is weight 2, second is weight 1.
    assign bank = {bank_sel[0], bank_sel[1]};
endmodule

// File: rtl/sdram_bank_table.sv
`timescale 1ns/1ps
// Per-bank open flag and the kept low bits of the open row.
// Assumes commands arrive already gated by chip select and clock enable.
module sdram_bank_table
    import sdram_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int ROW_KEEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cmd_e                cmd,
    input  logic [BANK_W-1:0]   bank,
    input  logic [ROW_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] open_vec,
    output logic [ROW_KEEP-1:0] row_q [NUM_BANKS]
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Open on activate to this bank; close on precharge of it or of all.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vec[b] <= 1'b0;
                row_q[b]    <= '0;
            end else if (cmd == CMD_ACT && bank == BANK_W'(b)) begin
                open_vec[b] <= 1'b1;
                row_q[b]    <= addr[ROW_KEEP-1:0];
            end else if (cmd == CMD_PRE && (addr[AP_BIT] || bank == BANK_W'(b))) begin
                open_vec[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdram_store.sv
`timescale 1ns/1ps
// Reduced storage array, one byte-wide memory per lane with its own write enable.
// Assumes asynchronous read and contents that are not reset.
module sdram_store #(
    parameter int AW    = 7,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic [LANES-1:0]   wr_be,
    input  logic [AW-1:0]      wr_addr,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [8*LANES-1:0] rd_data
);
    localparam int DEPTH = 2 ** AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        // Write this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_be[l]) mem[wr_addr] <= wr_data[8*l +: 8];
        end
        assign rd_data[8*l +: 8] = mem[rd_addr];
    end
endmodule

// File: rtl/sdram_burst_engine.sv
`timescale 1ns/1ps
// Runs four-beat wrapping bursts, applies byte masks and delays read data by two cycles.
// Assumes the bank table gives the open state and the kept row bits per bank.
module sdram_burst_engine
    import sdram_pkg::*;
#(
    parameter int COL_W    = 9,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3,
    parameter int LANES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 edge_ok,
    input  cmd_e                 cmd,
    input  logic [BANK_W-1:0]    bank,
    input  logic [COL_W-1:0]     col,
    input  logic [NUM_BANKS-1:0] open_vec,
    input  logic [ROW_KEEP-1:0]  row_q [NUM_BANKS],
    input  logic [LANES-1:0]     dqm,
    input  logic [8*LANES-1:0]   dq_in,
    output logic [8*LANES-1:0]   dq_out,
    output logic [LANES-1:0]     dq_oe,
    output logic                 bad_access
);
    localparam int AW    = BANK_W + ROW_KEEP + COL_KEEP;
    localparam int REM_W = BIDX_W + 1;

    logic [REM_W-1:0]    bst_rem;
    logic                bst_rd;
    logic [BANK_W-1:0]   bst_bank;
    logic [ROW_KEEP-1:0] bst_row;
    logic [COL_W-1:0]    bst_col;
    logic [BIDX_W-1:0]   bst_idx;
    logic [COL_W-1:0]    beat_col;
    logic                hit, new_rd, new_wr, rw_cmd;
    logic [LANES-1:0]    wr_be;
    logic [AW-1:0]       wr_addr, rd_addr;
    logic [8*LANES-1:0]  rd_data, s1_data;
    logic                s1_v;
    logic [LANES-1:0]    dqm_d1, dqm_d2;

    // Classify the current command against the open state of its bank.
    always_comb begin
        rw_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
        hit    = open_vec[bank];
        new_rd = (cmd == CMD_RD) && hit;
        new_wr = (cmd == CMD_WR) && hit;
    end

    assign beat_col = {bst_col[COL_W-1:BIDX_W], bst_idx};
    assign rd_addr  = {bst_bank, bst_row, beat_col[COL_KEEP-1:0]};

    // Select the write port: the first beat of a new write, or a running write beat.
    always_comb begin
        wr_be   = '0;
        wr_addr = rd_addr;
        if (new_wr) begin
            wr_be   = ~dqm;
            wr_addr = {bank, row_q[bank], col[COL_KEEP-1:0]};
        end else if (edge_ok && bst_rem != '0 && !bst_rd) begin
            wr_be   = ~dqm;
        end
    end

    sdram_store #(.AW(AW), .LANES(LANES)) u_store (
        .clk     (clk),
        .wr_be   (wr_be),
        .wr_addr (wr_addr),
        .wr_data (dq_in),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Burst sequencing, read pipeline, mask delay and error pulse; all held on an invalid edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_rem    <= '0;
            bst_rd     <= 1'b0;
            bst_bank   <= '0;
            bst_row    <= '0;
            bst_col    <= '0;
            bst_idx    <= '0;
            s1_v       <= 1'b0;
            s1_data    <= '0;
            dqm_d1     <= '0;
            dqm_d2     <= '0;
            dq_out     <= '0;
            dq_oe      <= '0;
            bad_access <= 1'b0;
        end else if (edge_ok) begin
            bad_access <= rw_cmd && !hit;
            dqm_d1     <= dqm;
            dqm_d2     <= dqm_d1;
            dq_out     <= s1_data;
            dq_oe      <= {LANES{s1_v}} & ~dqm_d2;
            s1_v       <= 1'b0;
            if (new_rd || new_wr) begin
                bst_rd   <= new_rd;
                bst_bank <= bank;
                bst_row  <= row_q[bank];
                bst_col  <= col;
                bst_rem  <= new_rd ? REM_W'(BURST_LEN) : REM_W'(BURST_LEN - 1);
                bst_idx  <= new_rd ? col[BIDX_W-1:0] : col[BIDX_W-1:0] + 1'b1;
            end else if (bst_rem != '0) begin
                bst_rem <= bst_rem - 1'b1;
                bst_idx <= bst_idx + 1'b1;
                if (bst_rd) begin
                    s1_v    <= 1'b1;
                    s1_data <= rd_data;
                end
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_model.sv
`timescale 1ns/1ps
// Top of the device-side DRAM model: clock-enable register, decoder, bank table, burst engine.
// Assumes a single clock and a synchronous active-low reset; data path is 16 bits.
module sdram_cmd_model
    import sdram_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int COL_W    = 9,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        bank_sel,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W/8-1:0] dqm,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W/8-1:0] dq_oe,
    output logic              bad_access
);
    localparam int LANES = DATA_W / 8;

    logic                 edge_ok;
    cmd_e                 cmd;
    logic [BANK_W-1:0]    bank;
    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_KEEP-1:0]  row_q [NUM_BANKS];

    // Register the clock enable: its sampled value qualifies the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_ok <= 1'b1;
        else        edge_ok <= cke;
    end

    sdram_cmd_decode u_dec (
        .edge_ok  (edge_ok),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_sel (bank_sel),
        .cmd      (cmd),
        .bank     (bank)
    );

    sdram_bank_table #(.ROW_W(ROW_W), .ROW_KEEP(ROW_KEEP)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .bank     (bank),
        .addr     (addr),
        .open_vec (open_vec),
        .row_q    (row_q)
    );

    sdram_burst_engine #(
        .COL_W(COL_W), .ROW_KEEP(ROW_KEEP), .COL_KEEP(COL_KEEP), .LANES(LANES)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_ok    (edge_ok),
        .cmd        (cmd),
        .bank       (bank),
        .col        (addr[COL_W-1:0]),
        .open_vec   (open_vec),
        .row_q      (row_q),
        .dqm        (dqm),
        .dq_in      (dq_in),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .bad_access (bad_access)
    );
endmodule

// File: rtl/sdram_cmd_model_chk.sv
`timescale 1ns/1ps
// Property checker for the DRAM model, attached to the top by bind.
// Assumes the 13-bit address and two byte lanes of the default configuration.
module sdram_cmd_model_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [12:0] addr,
    input logic [1:0]  dqm,
    input logic [15:0] dq_out,
    input logic [1:0]  dq_oe,
    input logic        bad_access,
    input logic        edge_ok,
    input logic [3:0]  open_vec
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dq_oe == 2'b00 && !bad_access && open_vec == 4'b0000));

    p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(open_vec));

    p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ok && !cs_n && !ras_n && cas_n && !we_n && addr[10]) |=> (open_vec == 4'b0000));

    p_rmask_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_ok) && $past(edge_ok, 2) && $past(edge_ok, 3)) |-> ((dq_oe & $past(dqm, 3)) == 2'b00));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_access) |-> $past(!cs_n && ras_n && !cas_n));

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_ok |=> ($stable(dq_out) && $stable(dq_oe) && $stable(open_vec) && $stable(bad_access)));
endmodule

bind sdram_cmd_model sdram_cmd_model_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .dqm        (dqm),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .bad_access (bad_access),
    .edge_ok    (edge_ok),
    .open_vec   (open_vec)
);

// File: tb/sdram_cmd_model_test.sv
`timescale 1ns/1ps
module sdram_cmd_model_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank_sel = 2'b00;
    logic [12:0] addr = '0;
    logic [1:0]  dqm = 2'b00;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        bad_access;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mdl [0:127];
    bit          mopen [4];
    logic [12:0] mrow [4];

    sdram_cmd_model uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
        .dqm(dqm), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .bad_access(bad_access)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int midx(input logic [1:0] b, input logic [12:0] r, input logic [8:0] c);
        return int'(b) * 32 + int'(r[1:0]) * 8 + int'(c[2:0]);
    endfunction

    function automatic logic [15:0] wdat(input int b, input int s, input int i);
        return 16'(4096 * b + 256 * s + 17 * i + 3);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_cmd(input logic [2:0] rcw, input logic [1:0] b, input logic [12:0] a);
        cs_n = 1'b0;
        {ras_n, cas_n, we_n} = rcw;
        bank_sel = {b[0], b[1]};
        addr = a;
    endtask

    task automatic idle(input bit noise);
        if (noise) begin
            cs_n = 1'b1;
            {ras_n, cas_n, we_n} = 3'b010;
            addr = 13'h1FFF;
        end else begin
            cs_n = 1'b0;
            {ras_n, cas_n, we_n} = 3'b111;
            addr = '0;
        end
    endtask

    task automatic activate(input logic [1:0] b, input logic [12:0] r);
        put_cmd(3'b011, b, r);
        step();
        idle(0);
        mopen[b] = 1;
        mrow[b] = r;
    endtask

    task automatic precharge(input logic [1:0] b, input bit all);
        put_cmd(3'b010, b, all ? 13'h0400 : 13'h0000);
        step();
        idle(0);
        for (int k = 0; k < 4; k++) if (all || k == int'(b)) mopen[k] = 0;
    endtask

    task automatic write_burst(input logic [1:0] b, input logic [8:0] col, input logic [63:0] d,
                               input logic [7:0] m);
        for (int i = 0; i < 4; i++) begin
            logic [8:0] c;
            c = {col[8:2], 2'(col[1:0] + i)};
            if (i == 0) put_cmd(3'b100, b, {4'b0, col});
            else idle(0);
            dq_in = d[16*i +: 16];
            dqm = m[2*i +: 2];
            if (mopen[b]) begin
                if (!m[2*i])     mdl[midx(b, mrow[b], c)][7:0]  = d[16*i +: 8];
                if (!m[2*i + 1]) mdl[midx(b, mrow[b], c)][15:8] = d[16*i + 8 +: 8];
            end
            step();
            if (i == 0) check(mopen[b] ? "R7" : "R10", "write error flag", {31'b0, bad_access}, {31'b0, !mopen[b]});
        end
        dqm = 2'b00;
    endtask

    task automatic read_burst(input logic [1:0] b, input logic [8:0] col, input logic [7:0] rm,
                              input string req, input bit noise);
        logic [15:0] ed [4];
        bit hit;
        hit = mopen[b];
        for (int i = 0; i < 4; i++) ed[i] = mdl[midx(b, mrow[b], {col[8:2], 2'(col[1:0] + i)})];
        put_cmd(3'b101, b, {4'b0, col});
        dqm = rm[1:0];
        step();
        check(hit ? req : "R10", "read error flag", {31'b0, bad_access}, {31'b0, !hit});
        idle(noise);
        for (int k = 1; k <= 6; k++) begin
            dqm = (k < 4) ? rm[2*k +: 2] : 2'b00;
            step();
            if (k == 1 && !hit) check("R10", "error pulse width", {31'b0, bad_access}, 32'd0);
            if (k >= 2) begin
                logic [1:0]  eoe;
                logic [15:0] lm, edat;
                int bi;
                bi = k - 2;
                eoe = (hit && bi < 4) ? ~rm[2*bi +: 2] : 2'b00;
                edat = (bi < 4) ? ed[bi] : 16'h0;
                lm = {{8{eoe[1]}}, {8{eoe[0]}}};
                check(req, $sformatf("bank %0d col %0d beat %0d", b, col, bi),
                      {14'b0, dq_oe, dq_out & lm}, {14'b0, eoe, edat & lm});
            end
        end
        idle(0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            mopen[k] = 0;
            mrow[k] = '0;
        end
        idle(0);
        cs_n = 1'b1;
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R1: reset state at the ports
        check("R1", "dq_oe after reset", {30'b0, dq_oe}, 32'd0);
        check("R1", "error flag after reset", {31'b0, bad_access}, 32'd0);
        for (int b = 0; b < 4; b++) read_burst(2'(b), 9'd0, 8'h00, "R1", 0);

        // R4, R6, R7: every bank, every start offset within a block
        for (int b = 0; b < 4; b++) begin
            activate(2'(b), 13'(b + 1));
            for (int s = 0; s < 4; s++) begin
                logic [8:0] c;
                c = 9'(s + 4 * (s % 2));
                write_burst(2'(b), c, {wdat(b, s, 3), wdat(b, s, 2), wdat(b, s, 1), wdat(b, s, 0)}, 8'h00);
                read_burst(2'(b), c, 8'h00, "R6", 0);
            end
        end
        // R4: banks keep independent rows when read interleaved
        for (int b = 3; b >= 0; b--) read_burst(2'(b), 9'd1, 8'h00, "R4", 0);

        // R8: write mask per beat and per byte
        write_burst(2'd1, 9'd3, 64'hA1A2_B1B2_C1C2_D1D2, {2'b01, 2'b10, 2'b11, 2'b00});
        read_burst(2'd1, 9'd3, 8'h00, "R8", 0);
        // R9: read mask two cycles late
        read_burst(2'd1, 9'd0, {2'b10, 2'b01, 2'b11, 2'b00}, "R9", 0);
        read_burst(2'd0, 9'd6, {2'b00, 2'b01, 2'b00, 2'b10}, "R9", 0);

        // R12: aliased row and column
        activate(2'd2, 13'd7);
        read_burst(2'd2, 9'd9, 8'h00, "R12", 0);
        activate(2'd2, 13'd1027);
        read_burst(2'd2, 9'd261, 8'h00, "R12", 0);

        // R2: refresh and mode set change nothing
        put_cmd(3'b001, 2'd0, 13'h0400); step();
        put_cmd(3'b000, 2'd1, 13'h0400); step();
        idle(0);
        read_burst(2'd0, 9'd2, 8'h00, "R2", 0);

        // R3: chip select high during a burst with precharge-all on the pins
        read_burst(2'd3, 9'd4, 8'h00, "R3", 1);
        read_burst(2'd3, 9'd5, 8'h00, "R3", 0);

        // R5: single-bank precharge
        precharge(2'd1, 0);
        read_burst(2'd1, 9'd0, 8'h00, "R5", 0);
        read_burst(2'd2, 9'd0, 8'h00, "R5", 0);
        // R10: write to a closed bank leaves storage alone
        write_burst(2'd1, 9'd0, 64'hDEAD_BEEF_0BAD_F00D, 8'h00);
        activate(2'd1, 13'd2);
        read_burst(2'd1, 9'd0, 8'h00, "R10", 0);
        // R5: precharge all
        precharge(2'd2, 1);
        for (int b = 0; b < 4; b++) read_burst(2'(b), 9'd4, 8'h00, "R5", 0);

        // R3: activate with chip select high is ignored
        put_cmd(3'b011, 2'd0, 13'd1);
        cs_n = 1'b1;
        step();
        idle(0);
        read_burst(2'd0, 9'd0, 8'h00, "R3", 0);

        // R11: clock enable low freezes one edge in the read-data window
        activate(2'd0, 13'd1);
        begin
            logic [15:0] eb [4];
            for (int i = 0; i < 4; i++) eb[i] = mdl[midx(2'd0, 13'd1, 9'(4 + i))];
            put_cmd(3'b101, 2'd0, 13'd4);
            step();
            idle(0);
            step();
            step();
            check("R11", "beat0 before freeze", {15'b0, dq_oe == 2'b11, dq_out}, {15'b0, 1'b1, eb[0]});
            cke = 1'b0;
            step();
            check("R11", "beat1 before frozen edge", {15'b0, dq_oe == 2'b11, dq_out}, {15'b0, 1'b1, eb[1]});
            cke = 1'b1;
            put_cmd(3'b010, 2'd0, 13'h0400);
            step();
            idle(0);
            check("R11", "output held on frozen edge", {15'b0, dq_oe == 2'b11, dq_out}, {15'b0, 1'b1, eb[1]});
            step();
            check("R11", "beat2 after freeze", {15'b0, dq_oe == 2'b11, dq_out}, {15'b0, 1'b1, eb[2]});
            step();
            check("R11", "beat3 after freeze", {15'b0, dq_oe == 2'b11, dq_out}, {15'b0, 1'b1, eb[3]});
            step();
            check("R11", "burst end after freeze", {30'b0, dq_oe}, 32'd0);
        end
        read_burst(2'd0, 9'd4, 8'h00, "R11", 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule